// File: doc/BRIEF.md
# Serial-Bus Target With 512-Byte Random-Read Memory

This block is an I2C target placed in front of a 512-byte storage array. A fast system clock oversamples the bus clock and data lines. The block finds start and stop conditions and shifts bytes in and out. The open-drain data line is modelled as a sampled input `sda_i` together with a pull-low enable `sda_oe`. The bus line is low whenever `sda_oe` is 1.

A read at a random address is done in two steps. First, the controller sends a dummy write. Its address byte carries the top memory address bit, and the byte after it carries the low eight bits. Together they load a 9-bit address counter. Second, with no stop in between, the controller sends a repeated start and an address byte with the read flag set. The target then shifts out the addressed byte. If the controller acknowledges a byte, the next location follows. If it answers with a not-acknowledge and a stop, the target releases the line and goes idle.

A preload port writes the array directly so that a test can give it contents. There is no write path from the bus into the array.

Top module: `i2c_rr_mem`

## Requirements
- R1: The target acknowledges an address byte only when its bits 7..4 equal 1010. For any other value it does not acknowledge, and it keeps the data line released until the next start.
- R2: Bit 1 of the write-mode address byte becomes address bit 8. The following byte (MSB first) becomes address bits 7..0. Together they load the 9-bit address counter.
- R3: Bit 0 of the address byte selects the direction: 0 is write, 1 is read. A read address byte starts data transmission from the current counter.
- R4: On the ninth SCL pulse of each address byte and each word-address byte that the target accepts, it pulls the data line low.
- R5: After acknowledging a read address byte, the target drives the byte stored at the counter, bit 7 first and bit 0 last.
- R6: After a data byte that the controller does not acknowledge, followed by a stop, the data line stays released.
- R7: After each transmitted byte the counter advances by one and wraps from 511 to 0. A controller acknowledge causes the next byte to be sent.
- R8: A start condition at any bit position restarts address-byte reception from the first bit.
- R9: The target changes `sda_oe` only while SCL is low.
- R10: Bits 3 and 2 of the address byte do not affect matching or the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 9 | Preload location |
| pre_data | input | 8 | Preload byte |

## Verification
The hardest situation to reach is a start condition that arrives partway through a byte. Here the bit counter must discard the partial byte instead of finishing it. The bench sends three bits of an address byte, issues a new start, and then runs a full random read that must return the right byte. A second hard case is the wrap of the address counter from 511 to 0 during a sequential read. The bench reaches it by loading address 511 through a dummy write with bit 8 set, then acknowledging the first data byte.

// File: rtl/i2c_rr_mem.sv
module i2c_rr_mem #(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       pre_we,
  input  logic [8:0] pre_addr,
  input  logic [7:0] pre_data
);
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_TX, S_HOLD, S_SKIP} st_t;

  logic [7:0] mem [512];
  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [8:0] addr;
  logic       a8, own_ack, oe;

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire start_c = scl_s && scl_p && sda_p && !sda_s;
  wire stop_c  = scl_s && scl_p && !sda_p && sda_s;
  wire scl_r   = scl_s && !scl_p;
  wire scl_f   = !scl_s && scl_p;
  wire [7:0] rd_byte = mem[addr];

  assign sda_oe = oe;

  always_ff @(posedge clk)
    if (pre_we) mem[pre_addr] <= pre_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i}; sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_s; sda_p <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; addr <= '0;
      a8 <= 1'b0; own_ack <= 1'b0; oe <= 1'b0;
    end else if (start_c) begin
      st <= S_DEV; cnt <= '0; oe <= 1'b0; own_ack <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; cnt <= '0; oe <= 1'b0; own_ack <= 1'b0;
    end else if (scl_r) begin
      if (cnt != 4'd9) cnt <= cnt + 4'd1;
      if (cnt < 4'd8 && st != S_TX) sh <= {sh[6:0], sda_s};
      if (cnt == 4'd8 && st == S_TX && !own_ack && sda_s) st <= S_SKIP;
    end else if (scl_f) begin
      if (cnt == 4'd8) begin
        case (st)
          S_DEV:
            if (sh[7:4] == DEV_CODE) begin
              oe <= 1'b1; own_ack <= 1'b1; a8 <= sh[1];
              st <= sh[0] ? S_TX : S_WADDR;
            end else st <= S_SKIP;
          S_WADDR: begin
            oe <= 1'b1; own_ack <= 1'b1; addr <= {a8, sh}; st <= S_HOLD;
          end
          S_TX: begin
            oe <= 1'b0; addr <= addr + 9'd1;
          end
          default: ;
        endcase
      end else if (cnt == 4'd9) begin
        cnt <= '0; own_ack <= 1'b0; oe <= 1'b0;
        if (st == S_TX) begin
          sh <= rd_byte; oe <= ~rd_byte[7];
        end
      end else if (st == S_TX && cnt != 4'd0) begin
        sh <= {sh[6:0], 1'b0}; oe <= ~sh[6];
      end
    end
endmodule

module i2c_rr_mem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic [3:0] cnt,
  input logic       start_c,
  input logic       stop_c,
  input logic       quiet
);
  a_r9_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  a_r8_start_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> cnt == 4'd0);
  a_r6_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);
  a_r1_quiet_released: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !sda_oe);
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd9);
endmodule

bind i2c_rr_mem i2c_rr_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .cnt(cnt),
  .start_c(start_c), .stop_c(stop_c), .quiet(st == S_IDLE || st == S_SKIP)
);

// File: tb/test_i2c_rr_mem.sv
module test_i2c_rr_mem;
  logic clk = 0, rst_n = 0, scl = 1, m_sda = 1;
  logic pre_we = 0;
  logic [8:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic sda_oe;
  wire sda_bus = m_sda & ~sda_oe;
  int checks = 0, fails = 0, viol = 0;
  logic prev_oe = 0;
  localparam int Q = 8, H = 16;

  always #2.5 clk = ~clk;

  i2c_rr_mem i_i2c_rr_mem (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data));

  always @(negedge clk) begin
    if (rst_n && scl && sda_oe != prev_oe) viol++;
    prev_oe = sda_oe;
  end

  function automatic logic [7:0] f(input logic [8:0] a);
    return a[7:0] * 8'd37 + (a[8] ? 8'd101 : 8'd0) + 8'd11;
  endfunction

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic i2c_start();
    m_sda = 1; w(Q); scl = 1; w(H); m_sda = 0; w(H); scl = 0; w(Q);
  endtask
  task automatic i2c_stop();
    w(Q); m_sda = 0; w(Q); scl = 1; w(H); m_sda = 1; w(H);
  endtask
  task automatic send_bit(input bit b);
    w(Q); m_sda = b; w(Q); scl = 1; w(H); scl = 0;
  endtask
  task automatic recv_bit(output bit v);
    w(Q); m_sda = 1; w(Q); scl = 1; w(Q); v = sda_bus; w(Q); scl = 0;
  endtask
  task automatic wr_byte(input logic [7:0] b, output bit ack);
    bit v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(v); ack = !v;
  endtask
  task automatic rd_byte(output logic [7:0] d, input bit mack);
    bit v;
    for (int i = 7; i >= 0; i--) begin recv_bit(v); d[i] = v; end
    send_bit(!mack);
  endtask

  task automatic set_addr(input logic [8:0] a, input logic [1:0] dc, output bit k1, output bit k2);
    i2c_start();
    wr_byte({4'b1010, dc, a[8], 1'b0}, k1);
    wr_byte(a[7:0], k2);
  endtask

  task automatic t_random_read(input logic [8:0] a, input logic [1:0] dc);
    bit k1, k2, k3; logic [7:0] d;
    set_addr(a, dc, k1, k2);
    i2c_start();
    wr_byte({4'b1010, dc, 1'b0, 1'b1}, k3);
    rd_byte(d, 0);
    i2c_stop();
    chk(k1 && k2, "R4 ack addr/word", {k1, k2}, 2'b11);
    chk(k3, "R3 read byte acked", k3, 1);
    chk(d == f(a), (dc != 0) ? "R10 dont-care bits" : "R2 R5 data at address", d, f(a));
    chk(!sda_oe, "R6 released after nack+stop", sda_oe, 0);
  endtask

  task automatic t_bad_code();
    bit k; logic [7:0] d;
    i2c_start();
    wr_byte(8'h92, k);
    chk(!k, "R1 wrong code not acked", k, 0);
    rd_byte(d, 0);
    chk(d == 8'hFF, "R1 line stays released", d, 8'hFF);
    i2c_stop();
  endtask

  task automatic t_seq_wrap();
    bit k1, k2, k3; logic [7:0] d0, d1, d2;
    set_addr(9'h1FF, 2'b00, k1, k2);
    i2c_start();
    wr_byte(8'hA1, k3);
    rd_byte(d0, 1); rd_byte(d1, 1); rd_byte(d2, 0);
    i2c_stop();
    chk(d0 == f(9'h1FF), "R7 first byte", d0, f(9'h1FF));
    chk(d1 == f(9'h000), "R7 wrap to 0", d1, f(9'h000));
    chk(d2 == f(9'h001), "R7 increment", d2, f(9'h001));
    i2c_start();
    wr_byte(8'hA1, k3);
    rd_byte(d0, 0);
    i2c_stop();
    chk(d0 == f(9'h002), "R7 counter kept after stop", d0, f(9'h002));
  endtask

  task automatic t_mid_start();
    i2c_start();
    send_bit(1); send_bit(0); send_bit(1);
    t_random_read(9'h0C7, 2'b00);
  endtask

  initial begin
    w(5);
    for (int i = 0; i < 512; i++) begin
      pre_addr = 9'(i); pre_data = f(9'(i)); pre_we = 1; w(1);
    end
    pre_we = 0; w(3); rst_n = 1; w(5);
    chk(sda_oe == 0, "R6 reset released", sda_oe, 0);
    t_random_read(9'h005, 2'b00);
    t_random_read(9'h1A3, 2'b11);
    t_bad_code();
    t_seq_wrap();
    t_mid_start();
    chk(viol == 0, "R9 oe stable while SCL high", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule